// File: doc/BRIEF.md
# Programmable Watchdog Fault Detector

This block watches one watchdog input. Either a rising or a falling level change restarts a timeout count. If the programmed window passes with no change, two things happen in the same clock cycle: a sticky fault flag is raised, and a single reset pulse of programmable width is started. The timer then reloads and keeps watching, so a host that stays silent gets one reset pulse per window.

All timing is counted in cycles of a time-base `tick` input, which is nominally one strobe every 10 µs. The window is chosen from seven doubling steps, and one code disables the detector. The pulse width is chosen from four decade steps. A small register port holds the configuration register and an output-inversion register. Two read strobes stand for reads of two fault status registers. The sticky flag clears only when the first one is read and then the second one.

Top module: `wdt_fault_det`

## Requirements
- R1: A level change of either polarity on `wd_in` restarts the timeout count. The restart takes effect at the third rising clock edge after the change, because the input passes through two synchronizing flip-flops before the edge detector.
- R2: Timeout code 0 (configuration bits [2:0] = 000) disables the detector, and no fault occurs. The configuration resets to 0x00, so the block is disabled after reset.
- R3: Timeout code c in 1..7 makes the fault occur BASE_TICKS·2^(c−1) ticks after the last restart, with no input change in between.
- R4: Pulse code p (configuration bits [4:3]) gives a reset pulse of PULSE_UNIT_TICKS·10^p ticks, for p = 0..3.
- R5: The register map is as follows. Address 0 is the configuration register: bits [4:0] are stored, bits [7:5] read as 0, and the reset value is 0x00. Address 1 is the inversion register: bit 0 inverts `wd_fault` and bit 1 inverts `wd_reset`. Any other address reads 0, and `reg_rdata` is 0 while `reg_rd` is low.
- R6: On a timeout, the fault flag and the reset pulse rise on the same clock edge.
- R7: The flag clears only on a strobe of `flt_rd_b` that follows an earlier strobe of `flt_rd_a`. A strobe of `flt_rd_b` with no earlier `flt_rd_a` is ignored, and the flag stays set.
- R8: After a timeout the timer reloads. A further timeout while the flag is set gives another pulse, and the flag stays set.
- R9: Any write to the configuration register restarts the timeout count. A write of timeout code 0 also ends any reset pulse at once.
- R10: When a timeout falls in the same cycle as the clearing strobe of `flt_rd_b`, the flag stays set.
- R11: With the inversion bits set, the outputs show the complement: `wd_fault` is high while idle, and the reset pulse is high-low-high.
- R12: Only cycles with `tick` high advance the timeout count and the pulse count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base strobe, one clock wide |
| wd_in | input | 1 | Watchdog input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flt_rd_a | input | 1 | Read strobe of the first fault status register |
| flt_rd_b | input | 1 | Read strobe of the second fault status register |
| wd_fault | output | 1 | Sticky fault flag, after optional inversion |
| wd_reset | output | 1 | Reset pulse, after optional inversion |

## Verification
The two functions that can fall in the same cycle are the timer's timeout, which sets the flag, and the second status read, which clears it. The bench writes the configuration to restart the count at a known edge. It places the first status read one cycle before the timeout edge and the second status read exactly on it, and the flag must read set afterwards. A normal clearing sequence right after that must still lower the flag. This shows that the result came from the set winning the collision, not from a broken clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Configuration register layout: pulse select in [4:3], timeout select in [2:0]
  typedef struct packed {
    logic [1:0] pulse_sel;
    logic [2:0] tmo_sel;
  } wdt_cfg_t;

  localparam int CFG_BITS      = 5;
  localparam int INV_FAULT_BIT = 0;
  localparam int INV_RESET_BIT = 1;

  // Window length in ticks: zero means disabled, otherwise base doubled (sel-1) times
  function automatic logic [31:0] tmo_ticks(input logic [2:0] sel, input int base);
    logic [31:0] b;
    b = 32'(base);
    if (sel == 3'd0) return 32'd0;
    return b << (sel - 3'd1);
  endfunction

  // Pulse length in ticks: unit times ten to the power sel
  function automatic logic [31:0] pulse_ticks(input logic [1:0] sel, input int unit);
    logic [31:0] m;
    m = 32'd1;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(sel)) m = m * 32'd10;
    end
    return m * 32'(unit);
  endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in,
  output logic wd_edge
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= wd_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // Any change of the synchronized level, either direction
  assign wd_edge = s2_q ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer import wdt_pkg::*; #(
  parameter int BASE_TICKS = 20000,
  parameter int CNT_W      = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] tmo_sel,
  input  logic       restart,
  output logic       timeout_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             enabled;

  assign limit       = CNT_W'(tmo_ticks(tmo_sel, BASE_TICKS));
  assign enabled     = (tmo_sel != 3'd0);
  assign timeout_evt = enabled && tick && !restart && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enabled || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= timeout_evt ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen import wdt_pkg::*; #(
  parameter int PULSE_UNIT_TICKS = 1,
  parameter int PW_W             = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] width_sel,
  input  logic       fire,
  input  logic       kill,
  output logic       pulse_on
);
  logic [PW_W-1:0] left_q;
  logic [PW_W-1:0] width;

  assign width    = PW_W'(pulse_ticks(width_sel, PULSE_UNIT_TICKS));
  assign pulse_on = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (kill) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= width;
    end else if (tick && pulse_on) begin
      left_q <= left_q - PW_W'(1);
    end
  end
endmodule

// File: rtl/wdt_fault_latch.sv
module wdt_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_first,
  input  logic rd_second,
  output logic flag
);
  logic armed_q;
  logic clear_ok;

  assign clear_ok = rd_second && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      if (set)           flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;

      if (clear_ok)      armed_q <= 1'b0;
      else if (rd_first) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_fault_det.sv
module wdt_fault_det import wdt_pkg::*; #(
  parameter int ADDR_W           = 4,
  parameter int BASE_TICKS       = 20000,
  parameter int PULSE_UNIT_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wd_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              flt_rd_a,
  input  logic              flt_rd_b,
  output logic              wd_fault,
  output logic              wd_reset
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] INV_ADDR = ADDR_W'(1);
  localparam int CNT_W = $clog2(BASE_TICKS * 64 + 1);
  localparam int PW_W  = $clog2(PULSE_UNIT_TICKS * 1000 + 1);

  wdt_cfg_t   cfg_q;
  logic [1:0] inv_q;

  // Named internal events, also used by the bound checker
  logic cfg_wr, inv_wr, cfg_kill;
  logic wd_edge, restart, timeout_evt, pulse_on, fault_flag;

  assign cfg_wr   = reg_wr && (reg_addr == CFG_ADDR);
  assign inv_wr   = reg_wr && (reg_addr == INV_ADDR);
  assign cfg_kill = cfg_wr && (reg_wdata[2:0] == 3'd0);
  assign restart  = cfg_wr || wd_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      inv_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= wdt_cfg_t'(reg_wdata[CFG_BITS-1:0]);
      if (inv_wr) inv_q <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      if (reg_addr == CFG_ADDR)      reg_rdata = {3'b000, cfg_q};
      else if (reg_addr == INV_ADDR) reg_rdata = {6'b0, inv_q};
    end
  end

  wdt_edge_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_in   (wd_in),
    .wd_edge (wd_edge)
  );

  wdt_timer #(
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tmo_sel     (cfg_q.tmo_sel),
    .restart     (restart),
    .timeout_evt (timeout_evt)
  );

  wdt_pulse_gen #(
    .PULSE_UNIT_TICKS (PULSE_UNIT_TICKS),
    .PW_W             (PW_W)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .width_sel (cfg_q.pulse_sel),
    .fire      (timeout_evt),
    .kill      (cfg_kill),
    .pulse_on  (pulse_on)
  );

  wdt_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (timeout_evt),
    .rd_first  (flt_rd_a),
    .rd_second (flt_rd_b),
    .flag      (fault_flag)
  );

  assign wd_fault = fault_flag ^ inv_q[INV_FAULT_BIT];
  assign wd_reset = pulse_on   ^ inv_q[INV_RESET_BIT];
endmodule

// File: rtl/wdt_fault_det_chk.sv
module wdt_fault_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [2:0] tmo_code,
  input logic       timeout_evt,
  input logic       pulse_on,
  input logic       fault_flag,
  input logic       cfg_kill,
  input logic       flt_rd_b
);
  // R6
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> pulse_on);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code == 3'd0) |-> !timeout_evt);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> fault_flag);

  // R7
  clear_by_second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> $past(flt_rd_b));

  // R8
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flt_rd_b) |=> fault_flag);

  // R9
  kill_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_kill |=> !pulse_on);

  // R12
  tick_gates_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !timeout_evt);
endmodule

bind wdt_fault_det wdt_fault_det_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .tmo_code    (cfg_q.tmo_sel),
  .timeout_evt (timeout_evt),
  .pulse_on    (pulse_on),
  .fault_flag  (fault_flag),
  .cfg_kill    (cfg_kill),
  .flt_rd_b    (flt_rd_b)
);

// File: tb/sim_wdt_fault_det.sv
`timescale 1ns/1ps
module sim_wdt_fault_det;
  localparam int AW   = 4;
  localparam int BASE = 8;
  localparam int UNIT = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic wd_in = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic flt_rd_a = 1'b0, flt_rd_b = 1'b0;
  logic wd_fault, wd_reset;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_div = 1;
  int phase = 0;
  int cycles = 0;
  logic inv_f = 1'b0;
  logic inv_r = 1'b0;

  always #5 clk = ~clk;

  wdt_fault_det #(.ADDR_W(AW), .BASE_TICKS(BASE), .PULSE_UNIT_TICKS(UNIT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_in(wd_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_rd_a(flt_rd_a), .flt_rd_b(flt_rd_b),
    .wd_fault(wd_fault), .wd_reset(wd_reset)
  );

  // time base
  always @(negedge clk) begin
    if (tick_div <= 1) begin
      tick = 1'b1;
      phase = 0;
    end else begin
      tick = (phase == 0);
      phase = (phase + 1) % tick_div;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    #1 d = int'(reg_rdata);
    reg_rd = 1'b0;
  endtask

  task automatic strobe_a();
    @(negedge clk); flt_rd_a = 1'b1; step(); flt_rd_a = 1'b0;
  endtask

  task automatic strobe_b();
    @(negedge clk); flt_rd_b = 1'b1; step(); flt_rd_b = 1'b0;
  endtask

  // cycles from the current negedge until the (un-inverted) flag is seen high
  task automatic wait_fault(input int lim, output int n);
    n = 0;
    while (1) begin
      step(); n++;
      if ((wd_fault ^ inv_f) == 1'b1) break;
      if (n >= lim) begin n = -1; break; end
    end
  endtask

  // pulse length in cycles, toggling the watchdog input to hold off retriggers
  task automatic measure_pulse(output int w);
    w = 0;
    while (((wd_reset ^ inv_r) == 1'b1) && w < 3000) begin
      w++;
      wd_in = ~wd_in;
      step();
    end
  endtask

  function automatic int exp_window(input int c);
    int v;
    v = BASE;
    for (int i = 1; i < c; i++) v = v * 2;
    return v;
  endfunction

  function automatic int exp_width(input int p);
    int v;
    v = UNIT;
    for (int i = 0; i < p; i++) v = v * 10;
    return v;
  endfunction

  initial begin
    int d, n, w, m;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // reset state
    chk("R2", "fault after reset", int'(wd_fault), 0);
    chk("R2", "reset pulse after reset", int'(wd_reset), 0);
    rd(0, d); chk("R5", "cfg reset value", d, 0);
    rd(1, d); chk("R5", "inv reset value", d, 0);

    // disabled after reset
    wait_fault(600, n);
    chk("R2", "no fault while disabled", n, -1);

    // reserved bits, readback, unmapped address, read enable
    wr(0, 8'hE0);
    rd(0, d); chk("R5", "reserved-only write reads 0", d, 0);
    wait_fault(300, n);
    chk("R2", "code 000 with reserved bits stays quiet", n, -1);
    wr(0, 8'hFF);
    rd(0, d); chk("R5", "cfg readback masks [7:5]", d, 8'h1F);
    wr(0, 8'h00);
    rd(5, d); chk("R5", "unmapped address reads 0", d, 0);
    @(negedge clk); reg_addr = '0; #1 chk("R5", "rdata idle when not reading", int'(reg_rdata), 0);
    idle(4);

    // sweep every window and every pulse width
    for (int p = 0; p < 4; p++) begin
      for (int c = 1; c < 8; c++) begin
        wr(0, (p << 3) | c);
        wait_fault(2000, n);
        chk("R3", $sformatf("window code %0d", c), n, exp_window(c));
        chk("R6", "pulse rises with flag", int'(wd_reset), 1);
        measure_pulse(w);
        chk("R4", $sformatf("pulse code %0d", p), w, exp_width(p));
        strobe_a(); strobe_b();
        chk("R7", "ordered reads clear flag", int'(wd_fault), 0);
        idle(3);
      end
    end
    wr(0, 0); idle(4);

    // read order
    wr(0, 8'h07);
    wait_fault(2000, n);
    measure_pulse(w);
    strobe_b();
    chk("R7", "second read alone ignored", int'(wd_fault), 1);
    strobe_b();
    chk("R7", "repeated second read ignored", int'(wd_fault), 1);
    strobe_a(); strobe_b();
    chk("R7", "first then second clears", int'(wd_fault), 0);
    wr(0, 0); idle(4);

    // repeat timeout while flag set
    wr(0, 8'h01);
    wait_fault(200, n);
    chk("R3", "window code 1 before repeat", n, BASE);
    m = 0;
    while (1) begin
      step(); m++;
      if (wd_reset == 1'b0) break;
      if (m > 50) break;
    end
    while (1) begin
      step(); m++;
      if (wd_reset == 1'b1 || m > 200) break;
    end
    chk("R8", "second pulse after one more window", m, BASE);
    chk("R8", "flag still set on repeat", int'(wd_fault), 1);
    wr(0, 0); strobe_a(); strobe_b(); idle(4);

    // either edge restarts (rising, then falling)
    for (int k = 0; k < 2; k++) begin
      wr(0, 8'h01);
      n = 0;
      while (1) begin
        step(); n++;
        if (n == 4) wd_in = ~wd_in;
        if (wd_fault == 1'b1 || n > 100) break;
      end
      chk("R1", k == 0 ? "rising edge restart" : "falling edge restart", n, 4 + 3 + BASE);
      wr(0, 0); strobe_a(); strobe_b(); idle(4);
    end

    // config write restarts the count
    wr(0, 8'h01);
    idle(4);
    wr(0, 8'h01);
    wait_fault(200, n);
    chk("R9", "rewrite restarts window", n, BASE);
    wr(0, 0); strobe_a(); strobe_b(); idle(4);

    // disable write ends a running pulse
    wr(0, 8'h19);
    wait_fault(200, n);
    for (int i = 0; i < 20; i++) begin wd_in = ~wd_in; step(); end
    chk("R9", "long pulse running", int'(wd_reset), 1);
    wr(0, 8'h00);
    chk("R9", "pulse ends on code 000 write", int'(wd_reset), 0);
    idle(50);
    chk("R9", "pulse stays off after disable", int'(wd_reset), 0);
    strobe_a(); strobe_b(); idle(4);

    // timeout collides with the clearing read
    wr(0, 8'h01);
    wait_fault(200, n);
    measure_pulse(w);
    wr(0, 8'h01);
    for (int i = 1; i <= 8; i++) begin
      step();
      flt_rd_a = (i == 6);
      flt_rd_b = (i == 7);
    end
    chk("R10", "timeout beats clearing read", int'(wd_fault), 1);
    wr(0, 0);
    strobe_a(); strobe_b();
    chk("R10", "control clear after collision", int'(wd_fault), 0);
    idle(4);

    // output inversion
    wr(1, 8'h03);
    rd(1, d); chk("R5", "inv readback", d, 3);
    inv_f = 1'b1; inv_r = 1'b1;
    chk("R11", "inverted idle fault", int'(wd_fault), 1);
    chk("R11", "inverted idle reset", int'(wd_reset), 1);
    wr(0, 8'h01);
    wait_fault(200, n);
    chk("R11", "inverted fault active low", int'(wd_fault), 0);
    chk("R11", "inverted pulse low", int'(wd_reset), 0);
    step();
    chk("R11", "inverted pulse returns high", int'(wd_reset), 1);
    wr(0, 0); strobe_a(); strobe_b();
    chk("R11", "inverted cleared flag reads high", int'(wd_fault), 1);
    wr(1, 0);
    inv_f = 1'b0; inv_r = 1'b0;
    idle(4);

    // sparse time base
    tick_div = 4;
    idle(8);
    wr(0, 8'h09);
    wait_fault(400, n);
    chk("R12", "window spans 8 ticks of 4 cycles", int'(n >= 4 * BASE - 3 && n <= 4 * BASE), 1);
    measure_pulse(w);
    chk("R12", "pulse of 10 ticks of 4 cycles", w, 40);
    wr(0, 0); strobe_a(); strobe_b();
    tick_div = 1;
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule